// File: doc/BRIEF.md
# Command-Word SPI Master Engine

This block is the shift engine of a SPI master. It pulls 32-bit command words from a transmit queue. Each word carries up to 16 bits of transmit data and its own control fields: which slave selects to drive, how many bits to shift, whether the transfer ends after this frame, and whether an inter-frame pause follows. The engine generates SCK from the system clock, drives MOSI and four slave-select lines, samples MISO, and hands each received word to the receive side as a one-cycle strobe.

Static configuration inputs set the SCK idle level, the clock phase, the shift order, a per-line select polarity, a clock divider, four programmable pauses counted in whole SCK periods, and an internal loopback. A queue of words with end-of-transfer clear keeps the selects asserted from frame to frame. This lets one chip-select window span many frames, with pauses between them where requested. Configuration is expected to change only while the engine is idle.

The controller has seven states. IDLE waits for a word. LEAD counts the pre pause after the selects assert. SHIFT clocks the frame. TRAIL counts the post pause before the selects release. XGAP counts the gap between transfers. FGAP counts the pause between frames. HOLD keeps the selects asserted while it waits for the next word. The transitions are as follows.
- IDLE→LEAD on a word when the pre pause is non-zero, otherwise IDLE→SHIFT.
- LEAD→SHIFT when the pre pause expires.
- SHIFT→TRAIL, →XGAP, →IDLE, →FGAP or →HOLD at frame end, according to the word's flags and the pause settings.
- TRAIL→XGAP or →IDLE.
- XGAP→IDLE.
- FGAP→HOLD.
- HOLD→SHIFT on the next word.

Top module: `spi_cmd_master`

## Requirements
- R1: Bits 15:0 of a command word hold the transmit data. Bits 27:24 hold the frame length minus one: values 3 to 15 shift 4 to 16 bits, and values 0 to 2 are treated as 3, a 4-bit frame. Each frame produces exactly two SCK transitions per bit.
- R2: When no frame is shifting, SCK rests at `cfg_cpol`: low for 0, high for 1.
- R3: With `cfg_cpha`=0, the first SCK edge of a frame comes one half period after the frame starts, and data is sampled on the leading edges. With `cfg_cpha`=1, the first edge comes at the start of the frame, and data is sampled on the trailing edges. MOSI changes only on the non-sampling edges.
- R4: `cfg_lsb_first`=0 shifts bit length-1 first. `cfg_lsb_first`=1 shifts bit 0 first. The same order applies when received bits are placed.
- R5: Bits 19:16 form an active-low select mask: a 0 in bit 16+n asserts select n, and 4'b1111 asserts none. Line n drives `cfg_sel_pol[n]` when it is asserted and the inverse when it is not.
- R6: Each SCK half period lasts `cfg_div`+1 system clocks.
- R7: The pre pause `cfg_pre_dly` puts 2·pre·(div+1) clocks between select assertion and the start of the first frame of a transfer.
- R8: When bit 20 (end-of-transfer) is set, the selects release 2·post·(div+1) clocks after the frame ends. The next word is then accepted 2·xfer·(div+1) clocks later.
- R9: When bit 20 is clear, the selects stay asserted. With bit 21 (end-of-frame) set, the next word is accepted 2·frame·(div+1) clocks after the frame ends; with bit 21 clear, it is accepted at once. A continuation frame starts without a pre pause.
- R10: At the end of each frame, `rx_valid` pulses for one cycle. `rx_data` then holds the received bits right-aligned, with the unused upper bits zero.
- R11: With `cfg_loopback`=1, the sampled input is MOSI instead of MISO.
- R12: After reset, the engine is idle: `tx_ready`=1, `rx_valid`=0, `mosi`=0, SCK is at its idle level, and all selects are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase selection |
| cfg_lsb_first | input | 1 | Shift order, 1 = bit 0 first |
| cfg_loopback | input | 1 | Sample MOSI instead of MISO |
| cfg_sel_pol | input | NSEL | Active level of each select line |
| cfg_div | input | DIV_W | Half-period length minus one, in clocks |
| cfg_pre_dly | input | DLY_W | Pause from select assertion to the first frame, in SCK periods |
| cfg_post_dly | input | DLY_W | Pause from the last frame to select release, in SCK periods |
| cfg_frame_dly | input | DLY_W | Pause after a frame flagged end-of-frame, in SCK periods |
| cfg_xfer_dly | input | DLY_W | Gap after a transfer, in SCK periods |
| tx_valid | input | 1 | Command word available |
| tx_ready | output | 1 | Engine accepts a word this cycle |
| tx_word | input | 32 | Command word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 16 | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | NSEL | Slave-select lines |

## Verification
The bench builds the engine with its default parameters: four select lines, a 16-bit divider and 4-bit pause fields. With these values the full command-word layout and every select position are reachable. The bench varies the run-time configuration instead: divider values 0, 1 and 3, and pauses of 0 to 3 periods. With these settings, the half-period, pre, post, frame and transfer pauses can each be measured in exact clock counts. A behavioural slave that follows the configured clock mode checks all four phase and polarity combinations, both shift orders, frame lengths at the clamp boundary and at 16 bits, and loopback.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int DATA_W  = 16;
    localparam int CMD_W   = 32;
    localparam int SEL_LSB = 16;
    localparam int EOT_BIT = 20;
    localparam int EOF_BIT = 21;
    localparam int LEN_LSB = 24;
    localparam int LEN_W   = 4;
    localparam int MIN_LM1 = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_XGAP,
        ST_FGAP,
        ST_HOLD
    } spim_state_e;
endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  lenm1,
    input  logic [LEN_W-1:0]  bit_idx,
    input  logic              lsb_first,
    input  logic              in_shift,
    input  logic              sample_en,
    input  logic              push,
    input  logic              din,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;
    logic [LEN_W-1:0]  tx_pos;

    always_comb begin
        tx_pos = lsb_first ? bit_idx : (lenm1 - bit_idx);
        mosi   = in_shift ? data_q[tx_pos] : 1'b0;
        if (lsb_first) begin
            acc_d = acc_q | (DATA_W'(din) << bit_idx);
        end else begin
            acc_d = {acc_q[DATA_W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            acc_q   <= '0;
            rx_data <= '0;
        end else begin
            if (load) begin
                data_q <= load_data;
                acc_q  <= '0;
            end else if (sample_en) begin
                acc_q <= acc_d;
            end
            if (push) begin
                rx_data <= acc_q;
            end
        end
    end

    // R10
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ((rx_data >> ({1'b0, $past(lenm1)} + 5'd1)) == '0));
endmodule

// File: rtl/spim_fsm.sv
module spim_fsm
    import spim_pkg::*;
#(
    parameter int NSEL  = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tx_valid,
    input  logic [NSEL-1:0]  new_sel_n,
    input  logic             new_eot,
    input  logic             new_eof,
    input  logic [LEN_W-1:0] new_len,
    input  logic [DLY_W-1:0] pre_dly,
    input  logic [DLY_W-1:0] post_dly,
    input  logic [DLY_W-1:0] frame_dly,
    input  logic [DLY_W-1:0] xfer_dly,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [NSEL-1:0]  sel_pol,
    output logic             tx_ready,
    output logic             accept,
    output logic             run,
    output logic             in_shift,
    output logic             sample_en,
    output logic             frame_end,
    output logic [LEN_W-1:0] lenm1,
    output logic [LEN_W-1:0] bit_idx,
    output logic             rx_valid,
    output logic             sck,
    output logic [NSEL-1:0]  ssel
);
    localparam int CNT_W = DLY_W + 1;
    localparam int H_W   = LEN_W + 1;

    spim_state_e      state_q, state_d;
    logic [H_W-1:0]   h_q, h_d;
    logic [CNT_W-1:0] dcnt_q, dcnt_d;
    logic [NSEL-1:0]  act_q;
    logic             eot_q, eof_q;
    logic [LEN_W-1:0] lenm1_q;
    logic             rxv_q;
    logic [H_W-1:0]   last_h;
    spim_state_e      after_trail, after_frame;

    function automatic logic [CNT_W-1:0] span_end(input logic [DLY_W-1:0] d);
        return {d, 1'b0} - CNT_W'(1);
    endfunction

    assign tx_ready  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
    assign accept    = tx_ready && tx_valid;
    assign run       = !tx_ready;
    assign in_shift  = (state_q == ST_SHIFT);
    assign last_h    = {lenm1_q, 1'b1};
    assign sample_en = in_shift && tick && !h_q[0];
    assign frame_end = in_shift && tick && (h_q == last_h);
    assign lenm1     = lenm1_q;
    assign bit_idx   = h_q[H_W-1:1];
    assign rx_valid  = rxv_q;

    always_comb begin
        after_trail = (xfer_dly != '0) ? ST_XGAP : ST_IDLE;
        if (eot_q) begin
            after_frame = (post_dly != '0) ? ST_TRAIL : after_trail;
        end else begin
            after_frame = (eof_q && frame_dly != '0) ? ST_FGAP : ST_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        h_d     = h_q;
        dcnt_d  = dcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_valid) begin
                    h_d     = '0;
                    dcnt_d  = '0;
                    state_d = (pre_dly != '0) ? ST_LEAD : ST_SHIFT;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (dcnt_q == span_end(pre_dly)) begin
                        state_d = ST_SHIFT;
                        h_d     = '0;
                    end else begin
                        dcnt_d = dcnt_q + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (h_q == last_h) begin
                        dcnt_d  = '0;
                        state_d = after_frame;
                    end else begin
                        h_d = h_q + 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (dcnt_q == span_end(post_dly)) begin
                        dcnt_d  = '0;
                        state_d = after_trail;
                    end else begin
                        dcnt_d = dcnt_q + 1'b1;
                    end
                end
            end
            ST_XGAP: begin
                if (tick) begin
                    if (dcnt_q == span_end(xfer_dly)) begin
                        state_d = ST_IDLE;
                    end else begin
                        dcnt_d = dcnt_q + 1'b1;
                    end
                end
            end
            ST_FGAP: begin
                if (tick) begin
                    if (dcnt_q == span_end(frame_dly)) begin
                        state_d = ST_HOLD;
                    end else begin
                        dcnt_d = dcnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tx_valid) begin
                    h_d     = '0;
                    state_d = ST_SHIFT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            h_q     <= '0;
            dcnt_q  <= '0;
            act_q   <= '0;
            eot_q   <= 1'b0;
            eof_q   <= 1'b0;
            lenm1_q <= LEN_W'(MIN_LM1);
            rxv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            h_q     <= h_d;
            dcnt_q  <= dcnt_d;
            rxv_q   <= frame_end;
            if (accept) begin
                act_q   <= ~new_sel_n;
                eot_q   <= new_eot;
                eof_q   <= new_eof;
                lenm1_q <= (new_len < LEN_W'(MIN_LM1)) ? LEN_W'(MIN_LM1) : new_len;
            end else if (state_d == ST_XGAP || state_d == ST_IDLE) begin
                act_q <= '0;
            end
        end
    end

    always_comb begin
        sck = cpol ^ (in_shift & (h_q[0] ^ cpha));
    end

    for (genvar n = 0; n < NSEL; n++) begin : g_sel
        assign ssel[n] = act_q[n] ? sel_pol[n] : ~sel_pol[n];
    end

    // R10
    rx_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state_q) == ST_SHIFT);
    // R8
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> act_q == '0);
    // R1
    bit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_shift |-> h_q <= last_h);
    // R9
    hold_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> $stable(act_q));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spim_pkg::*;
#(
    parameter int NSEL  = 4,
    parameter int DIV_W = 16,
    parameter int DLY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_loopback,
    input  logic [NSEL-1:0]   cfg_sel_pol,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_pre_dly,
    input  logic [DLY_W-1:0]  cfg_post_dly,
    input  logic [DLY_W-1:0]  cfg_frame_dly,
    input  logic [DLY_W-1:0]  cfg_xfer_dly,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [CMD_W-1:0]  tx_word,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NSEL-1:0]   ssel
);
    logic             tick, accept, run, in_shift, sample_en, frame_end;
    logic [LEN_W-1:0] lenm1, bit_idx;
    logic             din;
    logic             word_unused;

    assign word_unused = ^{tx_word[CMD_W-1:LEN_LSB+LEN_W], tx_word[LEN_LSB-1:EOF_BIT+1]};
    assign din = cfg_loopback ? mosi : miso;

    spim_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (cfg_div),
        .tick (tick)
    );

    spim_fsm #(.NSEL(NSEL), .DLY_W(DLY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tx_valid (tx_valid),
        .new_sel_n(tx_word[SEL_LSB +: NSEL]),
        .new_eot  (tx_word[EOT_BIT]),
        .new_eof  (tx_word[EOF_BIT]),
        .new_len  (tx_word[LEN_LSB +: LEN_W]),
        .pre_dly  (cfg_pre_dly),
        .post_dly (cfg_post_dly),
        .frame_dly(cfg_frame_dly),
        .xfer_dly (cfg_xfer_dly),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .sel_pol  (cfg_sel_pol),
        .tx_ready (tx_ready),
        .accept   (accept),
        .run      (run),
        .in_shift (in_shift),
        .sample_en(sample_en),
        .frame_end(frame_end),
        .lenm1    (lenm1),
        .bit_idx  (bit_idx),
        .rx_valid (rx_valid),
        .sck      (sck),
        .ssel     (ssel)
    );

    spim_datapath u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(tx_word[DATA_W-1:0]),
        .lenm1    (lenm1),
        .bit_idx  (bit_idx),
        .lsb_first(cfg_lsb_first),
        .in_shift (in_shift),
        .sample_en(sample_en),
        .push     (frame_end),
        .din      (din),
        .mosi     (mosi),
        .rx_data  (rx_data)
    );

    // R6
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(accept) && $stable(cfg_cpol) && $stable(cfg_cpha)) |-> $stable(sck));
endmodule

// File: tb/spi_cmd_master_test.sv
module spi_cmd_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_loopback = 0;
    logic [3:0]  cfg_sel_pol = 4'h0;
    logic [15:0] cfg_div = 16'd1;
    logic [3:0]  cfg_pre_dly = 0, cfg_post_dly = 0, cfg_frame_dly = 0, cfg_xfer_dly = 0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_word = '0;
    logic        tx_ready, rx_valid, sck, mosi;
    logic        miso_m = 1'b0;
    logic [15:0] rx_data;
    logic [3:0]  ssel;

    int checks = 0;
    int errors = 0;

    logic [15:0] s_pat, s_cap;
    int          s_len, s_k, s_n, s_edges;

    always #10 clk = ~clk;

    spi_cmd_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_loopback(cfg_loopback), .cfg_sel_pol(cfg_sel_pol),
        .cfg_div(cfg_div), .cfg_pre_dly(cfg_pre_dly), .cfg_post_dly(cfg_post_dly),
        .cfg_frame_dly(cfg_frame_dly), .cfg_xfer_dly(cfg_xfer_dly), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_word(tx_word), .rx_valid(rx_valid), .rx_data(rx_data),
        .sck(sck), .mosi(mosi), .miso(miso_m), .ssel(ssel)
    );

    // behavioural slave following the configured clock mode
    always @(posedge sck or negedge sck) begin : slave_model
        logic lead;
        if (rst_n) begin
            lead = (sck != cfg_cpol);
            s_edges++;
            if (lead != cfg_cpha) begin
                s_cap = {s_cap[14:0], mosi};
                s_n++;
            end else if (s_k < s_len) begin
                miso_m = cfg_lsb_first ? s_pat[s_k] : s_pat[s_len-1-s_k];
                s_k++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [15:0] d, input logic [3:0] sel_n,
                                       input bit eot, input bit eof, input logic [3:0] len);
        return {4'h0, len, 2'b00, eof, eot, sel_n, d};
    endfunction

    function automatic logic [15:0] rev(input logic [15:0] d, input int nb);
        logic [15:0] r = '0;
        for (int i = 0; i < nb; i++) r[nb-1-i] = d[i];
        return r;
    endfunction

    function automatic logic [15:0] lowmask(input int nb);
        return 16'((32'h1 << nb) - 1);
    endfunction

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic arm(input logic [15:0] pat, input int nb);
        s_pat = pat; s_len = nb; s_cap = '0; s_n = 0; s_edges = 0;
        if (!cfg_cpha) begin
            miso_m = cfg_lsb_first ? pat[0] : pat[nb-1];
            s_k = 1;
        end else begin
            miso_m = 1'b0;
            s_k = 0;
        end
    endtask

    task automatic send(input logic [31:0] w);
        tx_word = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic start_frame(input logic [31:0] w, input logic [15:0] pat, input int nb);
        arm(pat, nb);
        send(w);
    endtask

    task automatic finish_frame(input logic [31:0] w, input int nb, input logic [15:0] exp_rx, input string req);
        logic [15:0] got, exp_cap;
        @(negedge clk);
        while (!rx_valid) @(negedge clk);
        got = rx_data;
        check(got == exp_rx, req, "rx_data", got, exp_rx);
        exp_cap = cfg_lsb_first ? rev(w[15:0], nb) : (w[15:0] & lowmask(nb));
        check(s_cap == exp_cap, req, "bits seen on mosi", s_cap, exp_cap);
        check(s_edges == 2 * nb, req, "sck edge count", s_edges, 2 * nb);
    endtask

    task automatic wait_idle();
        while (!(tx_ready && ssel == ~cfg_sel_pol)) @(negedge clk);
    endtask

    task automatic count_until_sck_moves(output int n);
        n = 0;
        while (sck == cfg_cpol) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        check(tx_ready == 1'b1, "R12", "tx_ready", tx_ready, 1);
        check(rx_valid == 1'b0, "R12", "rx_valid", rx_valid, 0);
        check(mosi == 1'b0, "R12", "mosi", mosi, 0);
        check(sck == 1'b0, "R2", "idle sck", sck, 0);
        check(ssel == 4'hF, "R12", "ssel", ssel, 4'hF);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            logic [31:0] w;
            cfg_cpol = m[1]; cfg_cpha = m[0]; settle();
            check(sck == cfg_cpol, "R2", "idle sck", sck, cfg_cpol);
            w = mk(16'hC3A5, 4'b1110, 1, 0, 4'd15);
            start_frame(w, 16'h5A3C, 16);
            finish_frame(w, 16, 16'h5A3C, "R3");
            wait_idle();
            check(sck == cfg_cpol, "R2", "sck after frame", sck, cfg_cpol);
        end
        cfg_cpol = 0; cfg_cpha = 0; settle();
    endtask

    task automatic t_lsb_len();
        logic [31:0] w;
        cfg_lsb_first = 1; settle();
        w = mk(16'hFABC, 4'b1110, 1, 0, 4'd11);
        start_frame(w, 16'hFF35, 12);
        finish_frame(w, 12, 16'h0F35, "R4");
        wait_idle();
        cfg_lsb_first = 0; settle();
        w = mk(16'hFFF9, 4'b1110, 1, 0, 4'd3);
        start_frame(w, 16'h000A, 4);
        finish_frame(w, 4, 16'h000A, "R1");
        wait_idle();
        w = mk(16'hFFF6, 4'b1110, 1, 0, 4'd1);
        start_frame(w, 16'hFFF5, 4);
        finish_frame(w, 4, 16'h0005, "R1");
        wait_idle();
    endtask

    task automatic t_loopback();
        logic [31:0] w;
        cfg_loopback = 1; settle();
        w = mk(16'h1234, 4'b1110, 1, 0, 4'd15);
        start_frame(w, 16'hFFFF, 16);
        finish_frame(w, 16, 16'h1234, "R11");
        wait_idle();
        cfg_loopback = 0; settle();
    endtask

    task automatic t_selects();
        logic [31:0] w;
        cfg_sel_pol = 4'b0101; cfg_pre_dly = 1; settle();
        check(ssel == 4'b1010, "R5", "inactive ssel with polarity", ssel, 4'b1010);
        w = mk(16'h00A5, 4'b1011, 1, 0, 4'd7);
        start_frame(w, 16'h0033, 8);
        check(ssel == 4'b1110, "R5", "ssel with select 2 asserted", ssel, 4'b1110);
        finish_frame(w, 8, 16'h0033, "R5");
        wait_idle();
        w = mk(16'h0081, 4'b1111, 1, 0, 4'd7);
        start_frame(w, 16'h0042, 8);
        check(ssel == 4'b1010, "R5", "ssel with none asserted", ssel, 4'b1010);
        finish_frame(w, 8, 16'h0042, "R5");
        wait_idle();
        cfg_sel_pol = 4'h0; cfg_pre_dly = 0; settle();
    endtask

    task automatic t_div_pre();
        logic [31:0] w;
        int n;
        w = mk(16'h0069, 4'b1110, 1, 0, 4'd7);
        cfg_div = 16'd3; settle();
        start_frame(w, 16'h0011, 8); count_until_sck_moves(n);
        check(n == 4, "R6", "first edge, div 3", n, 4);
        finish_frame(w, 8, 16'h0011, "R6"); wait_idle();
        cfg_div = 16'd0; settle();
        start_frame(w, 16'h0022, 8); count_until_sck_moves(n);
        check(n == 1, "R6", "first edge, div 0", n, 1);
        finish_frame(w, 8, 16'h0022, "R6"); wait_idle();
        cfg_div = 16'd1; cfg_pre_dly = 3; settle();
        start_frame(w, 16'h0044, 8); count_until_sck_moves(n);
        check(n == 14, "R7", "pre pause, cpha 0", n, 14);
        finish_frame(w, 8, 16'h0044, "R7"); wait_idle();
        cfg_cpha = 1; settle();
        start_frame(w, 16'h0088, 8); count_until_sck_moves(n);
        check(n == 12, "R7", "pre pause, cpha 1", n, 12);
        finish_frame(w, 8, 16'h0088, "R7"); wait_idle();
        cfg_cpha = 0; cfg_pre_dly = 0; settle();
    endtask

    task automatic t_post_xfer();
        logic [31:0] w;
        int n;
        cfg_post_dly = 2; cfg_xfer_dly = 3; settle();
        w = mk(16'h00C7, 4'b1110, 1, 0, 4'd7);
        start_frame(w, 16'h0099, 8);
        finish_frame(w, 8, 16'h0099, "R8");
        check(ssel == 4'b1110, "R8", "ssel during post pause", ssel, 4'b1110);
        n = 0;
        while (ssel != 4'hF) begin @(negedge clk); n++; end
        check(n == 8, "R8", "post pause clocks", n, 8);
        n = 0;
        while (!tx_ready) begin @(negedge clk); n++; end
        check(n == 12, "R8", "transfer gap clocks", n, 12);
        cfg_post_dly = 0; cfg_xfer_dly = 0; settle();
    endtask

    task automatic t_continuation();
        logic [31:0] w;
        int n;
        cfg_pre_dly = 2; cfg_frame_dly = 2; settle();
        w = mk(16'h005C, 4'b1110, 0, 0, 4'd7);
        start_frame(w, 16'h0096, 8);
        finish_frame(w, 8, 16'h0096, "R9");
        n = 0;
        while (!tx_ready) begin @(negedge clk); n++; end
        check(n == 0, "R9", "ready after plain frame", n, 0);
        check(ssel == 4'b1110, "R9", "ssel kept", ssel, 4'b1110);
        w = mk(16'h00E1, 4'b1110, 0, 1, 4'd7);
        start_frame(w, 16'h0017, 8);
        count_until_sck_moves(n);
        check(n == 2, "R9", "continuation starts without pre pause", n, 2);
        finish_frame(w, 8, 16'h0017, "R9");
        n = 0;
        while (!tx_ready) begin @(negedge clk); n++; end
        check(n == 8, "R9", "frame pause clocks", n, 8);
        check(ssel == 4'b1110, "R9", "ssel through frame pause", ssel, 4'b1110);
        w = mk(16'h003E, 4'b1110, 1, 0, 4'd7);
        start_frame(w, 16'h00B4, 8);
        finish_frame(w, 8, 16'h00B4, "R9");
        wait_idle();
        check(ssel == 4'hF, "R8", "ssel released at end", ssel, 4'hF);
        cfg_pre_dly = 0; cfg_frame_dly = 0; settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_lsb_len();
        t_loopback();
        t_selects();
        t_div_pre();
        t_post_xfer();
        t_continuation();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule